// File: doc/BRIEF.md
# Serial Line Control Register File

This block is a small host-facing register file wrapped around a one-character serial receiver and a double-buffered serial transmitter. Software sees four 16-bit registers at byte offsets 0, 2, 4 and 6: receiver control/status, received character with error flags, transmitter control/status and transmit character. A single synchronous port is used for both reads and writes. Read data is combinational from the address. The side effects of a read take place at the clock edge on which `rd_en` is high.

Besides moving characters, the block drives three modem-control outputs and watches four modem-status inputs. Any change on those inputs can raise an interrupt. A reader-run control bit lets software admit one character at a time. A loopback test mode connects the transmitter to the receiver and runs both at the transmitter bit rate. Each frame is one start bit (0), then `DATA_BITS` data bits sent LSB first, then an optional parity bit, then one stop bit (1). The idle line is 1. The modem-status inputs are expected to be synchronous to `clk`.

Top module: `sl_line_regs`

## Requirements
- R1: After reset, offset 0 reads 0x0000, offset 2 reads 0x0000 and offset 4 reads 0x0080 (transmitter ready), and both interrupt outputs are low.
- R2: At offset 0, bits 6 (receive interrupt enable), 5 (modem interrupt enable), 3, 2, 1 and 0 are writable. Bit 3 drives `sec_tx`, bit 2 drives `rts`, bit 1 drives `dtr` and bit 0 drives `rdr_run`. Bits 14, 13, 12 and 10 read back `ring`, `cts`, `car_det` and `sec_rx`.
- R3: A received frame sets bit 7 of offset 0 at the middle of its stop bit and places the character, right-justified, in bits 7:0 of offset 2. Reading offset 2 clears bit 7 of offset 0.
- R4: In offset 2, bit 14 (overrun) is set when a character completes while the done bit is still set, and bit 13 (framing) when the stop bit samples as 0. Bit 12 (parity) is set when the received parity mismatches the configured sense (even when PARITY=1). Bit 15 is the OR of bits 14..12. All four bits are updated with every completed character.
- R5: Writing 1 to bit 0 of offset 0 clears the done bit. Bit 0 then clears itself when the next start bit is confirmed at its middle.
- R6: A write to offset 6 clears bit 7 of offset 4 for as long as the holding register is occupied. Bit 7 returns once the held character moves into the shifter. A second write made while a character is still shifting therefore keeps bit 7 low until that first frame ends.
- R7: Bit 0 of offset 4 (break) holds the transmitter line at 0 while it is set.
- R8: With bit 2 of offset 4 set, the receiver takes the transmitter line at the transmitter bit period (TX_DIV) and `txd` stays at 1.
- R9: Any change on `ring`, `car_det`, `cts` or `sec_rx` sets bit 15 of offset 0. A read of offset 0 clears it.
- R10: `rx_irq` is high when (done AND receive enable) OR (modem flag AND modem enable). `tx_irq` is high when transmitter ready AND bit 6 of offset 4 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 3 | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| rxd | input | 1 | External serial input |
| txd | output | 1 | External serial output |
| ring | input | 1 | Modem ring indicator |
| car_det | input | 1 | Modem carrier detect |
| cts | input | 1 | Modem clear to send |
| sec_rx | input | 1 | Modem secondary receive |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| sec_tx | output | 1 | Secondary transmit |
| rdr_run | output | 1 | Reader-run request (one character) |
| rx_irq | output | 1 | Receiver / modem interrupt request |
| tx_irq | output | 1 | Transmitter interrupt request |

## Verification
The assertions check these properties on every cycle:
- a data write drops transmitter ready on the next cycle;
- a data read clears done unless a character lands on the same edge;
- a confirmed start bit clears reader-run;
- a modem input change raises the modem flag;
- a holding-register transfer always leaves the shifter busy.

Frame contents need the bench's scenarios to show them: bit order, parity sense and justification. The same holds for the error flags under corrupted frames, overrun across two back-to-back characters, and loopback at the transmitter's own rate.

// File: rtl/sl_pkg.sv
package sl_pkg;
   localparam logic [2:0] OFS_RCSR = 3'd0;
   localparam logic [2:0] OFS_RBUF = 3'd2;
   localparam logic [2:0] OFS_XCSR = 3'd4;
   localparam logic [2:0] OFS_XBUF = 3'd6;

   localparam int PAR_NONE = 0;
   localparam int PAR_EVEN = 1;
   localparam int PAR_ODD  = 2;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sl_rx.sv
module sl_rx
   import sl_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int PARITY    = PAR_NONE,
   parameter int DIV_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line,
   input  logic [DIV_W-1:0]     div,
   output logic                 start_ok,
   output logic                 complete,
   output logic                 stop_bit,
   output logic [DATA_BITS-1:0] data,
   output logic                 par_err
);
   localparam int HAS_PAR = (PARITY != PAR_NONE) ? 1 : 0;
   localparam int NB      = DATA_BITS + HAS_PAR;
   localparam int NB_W    = $clog2(NB + 1);

   rx_state_e        st;
   logic [DIV_W-1:0] cnt;
   logic [NB-1:0]    sh;
   logic [NB_W-1:0]  nb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= RX_IDLE;
         cnt <= '0;
         sh  <= '0;
         nb  <= '0;
      end else begin
         case (st)
            RX_IDLE: if (!line) begin
               st  <= RX_START;
               cnt <= (div >> 1) - 1'b1;
            end
            RX_START: if (cnt == '0) begin
               if (!line) begin
                  st  <= RX_DATA;
                  cnt <= div - 1'b1;
                  nb  <= '0;
               end else begin
                  st <= RX_IDLE;
               end
            end else cnt <= cnt - 1'b1;
            RX_DATA: if (cnt == '0) begin
               sh  <= {line, sh[NB-1:1]};
               cnt <= div - 1'b1;
               if (nb == NB_W'(NB - 1)) st <= RX_STOP;
               else nb <= nb + 1'b1;
            end else cnt <= cnt - 1'b1;
            default: if (cnt == '0) st <= RX_IDLE;
               else cnt <= cnt - 1'b1;
         endcase
      end
   end

   assign start_ok = (st == RX_START) && (cnt == '0) && !line;
   assign complete = (st == RX_STOP) && (cnt == '0);
   assign stop_bit = line;
   assign data     = sh[DATA_BITS-1:0];

   generate
      if (HAS_PAR != 0) begin : g_par
         assign par_err = (^sh) != (PARITY == PAR_ODD);
      end else begin : g_nopar
         assign par_err = 1'b0;
      end
   endgenerate

   // R3: the stop phase is only ever entered from the data phase
   assert_stop_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_STOP && $past(st) != RX_STOP) |-> $past(st) == RX_DATA);
endmodule

// File: rtl/sl_tx.sv
module sl_tx
   import sl_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int PARITY    = PAR_NONE,
   parameter int DIV_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIV_W-1:0]     div,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] wdata,
   input  logic                 brk,
   output logic                 ready,
   output logic                 line
);
   localparam int HAS_PAR = (PARITY != PAR_NONE) ? 1 : 0;
   localparam int FL      = DATA_BITS + HAS_PAR + 2;
   localparam int FL_W    = $clog2(FL);

   logic [DATA_BITS-1:0] hold;
   logic                 hold_full;
   logic                 busy;
   logic [FL-1:0]        sh;
   logic [FL-1:0]        frame;
   logic [DIV_W-1:0]     cnt;
   logic [FL_W-1:0]      left;

   generate
      if (HAS_PAR != 0) begin : g_par
         logic pbit;
         assign pbit  = (^hold) ^ (PARITY == PAR_ODD);
         assign frame = {1'b1, pbit, hold, 1'b0};
      end else begin : g_nopar
         assign frame = {1'b1, hold, 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
         busy      <= 1'b0;
         sh        <= '1;
         cnt       <= '0;
         left      <= '0;
      end else begin
         if (!busy && hold_full) begin
            sh        <= frame;
            busy      <= 1'b1;
            cnt       <= div - 1'b1;
            left      <= FL_W'(FL - 1);
            hold_full <= 1'b0;
         end else if (busy) begin
            if (cnt == '0) begin
               if (left == '0) busy <= 1'b0;
               else begin
                  sh   <= {1'b1, sh[FL-1:1]};
                  left <= left - 1'b1;
                  cnt  <= div - 1'b1;
               end
            end else cnt <= cnt - 1'b1;
         end
         if (load) begin
            hold      <= wdata;
            hold_full <= 1'b1;
         end
      end
   end

   assign ready = !hold_full;
   assign line  = brk ? 1'b0 : (busy ? sh[0] : 1'b1);

   // R6: emptying the holding register always hands the character to the shifter
   assert_hold_to_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hold_full) && !$past(load)) |-> busy);
endmodule

// File: rtl/sl_line_regs.sv
module sl_line_regs
   import sl_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int PARITY    = PAR_NONE,
   parameter int RX_DIV    = 16,
   parameter int TX_DIV    = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  addr,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [15:0] wdata,
   output logic [15:0] rdata,
   input  logic        rxd,
   output logic        txd,
   input  logic        ring,
   input  logic        car_det,
   input  logic        cts,
   input  logic        sec_rx,
   output logic        dtr,
   output logic        rts,
   output logic        sec_tx,
   output logic        rdr_run,
   output logic        rx_irq,
   output logic        tx_irq
);
   localparam int DIV_MAX = (RX_DIV > TX_DIV) ? RX_DIV : TX_DIV;
   localparam int DIV_W   = $clog2(DIV_MAX + 1);

   initial begin : elab_checks
      assert (DATA_BITS >= 5 && DATA_BITS <= 8) else $error("DATA_BITS out of 5..8");
      assert (PARITY >= PAR_NONE && PARITY <= PAR_ODD) else $error("PARITY must be 0..2");
      assert (RX_DIV >= 4 && TX_DIV >= 4) else $error("bit dividers must be >= 4");
   end

   logic rie, mie, sec_q, rts_q, dtr_q, rdr_q;
   logic done, mflag, oe, fe, pe;
   logic [DATA_BITS-1:0] rchar;
   logic tie, maint, brk;
   logic [3:0] mod_q, mod_now;

   logic                 wr_rcsr, wr_xcsr, wr_xbuf, rd_rcsr, rd_rbuf;
   logic                 tx_line, tx_ready, rx_line;
   logic [DIV_W-1:0]     rx_div;
   logic                 rx_start_ok, rx_complete, rx_stop, rx_pe;
   logic [DATA_BITS-1:0] rx_data;
   logic [7:0]           char8;

   assign wr_rcsr = wr_en && (addr == OFS_RCSR);
   assign wr_xcsr = wr_en && (addr == OFS_XCSR);
   assign wr_xbuf = wr_en && (addr == OFS_XBUF);
   assign rd_rcsr = rd_en && (addr == OFS_RCSR);
   assign rd_rbuf = rd_en && (addr == OFS_RBUF);

   assign mod_now = {ring, cts, car_det, sec_rx};
   assign rx_line = maint ? tx_line : rxd;
   assign rx_div  = maint ? DIV_W'(TX_DIV) : DIV_W'(RX_DIV);

   sl_rx #(.DATA_BITS(DATA_BITS), .PARITY(PARITY), .DIV_W(DIV_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .line(rx_line), .div(rx_div),
      .start_ok(rx_start_ok), .complete(rx_complete), .stop_bit(rx_stop),
      .data(rx_data), .par_err(rx_pe));

   sl_tx #(.DATA_BITS(DATA_BITS), .PARITY(PARITY), .DIV_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .div(DIV_W'(TX_DIV)), .load(wr_xbuf),
      .wdata(wdata[DATA_BITS-1:0]), .brk(brk), .ready(tx_ready), .line(tx_line));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {rie, mie, sec_q, rts_q, dtr_q, rdr_q} <= '0;
         {done, mflag, oe, fe, pe}              <= '0;
         rchar <= '0;
         {tie, maint, brk} <= '0;
         mod_q <= '0;
      end else begin
         mod_q <= mod_now;
         if (wr_rcsr) begin
            rie   <= wdata[6];
            mie   <= wdata[5];
            sec_q <= wdata[3];
            rts_q <= wdata[2];
            dtr_q <= wdata[1];
            rdr_q <= wdata[0];
         end else if (rx_start_ok) begin
            rdr_q <= 1'b0;
         end
         if (wr_xcsr) begin
            tie   <= wdata[6];
            maint <= wdata[2];
            brk   <= wdata[0];
         end
         if (rd_rbuf || (wr_rcsr && wdata[0])) done <= 1'b0;
         if (rx_complete) begin
            done  <= 1'b1;
            oe    <= done;
            fe    <= !rx_stop;
            pe    <= rx_pe;
            rchar <= rx_data;
         end
         if (mod_now != mod_q) mflag <= 1'b1;
         else if (rd_rcsr)     mflag <= 1'b0;
      end
   end

   assign char8 = 8'(rchar);

   always_comb begin
      case (addr)
         OFS_RCSR: rdata = {mflag, ring, cts, car_det, 1'b0, sec_rx, 2'b00,
                            done, rie, mie, 1'b0, sec_q, rts_q, dtr_q, rdr_q};
         OFS_RBUF: rdata = {oe | fe | pe, oe, fe, pe, 4'b0000, char8};
         OFS_XCSR: rdata = {8'h00, tx_ready, tie, 3'b000, maint, 1'b0, brk};
         default:  rdata = 16'h0000;
      endcase
   end

   assign txd     = maint ? 1'b1 : tx_line;
   assign dtr     = dtr_q;
   assign rts     = rts_q;
   assign sec_tx  = sec_q;
   assign rdr_run = rdr_q;
   assign rx_irq  = (done && rie) || (mflag && mie);
   assign tx_irq  = tx_ready && tie;

   // R6: a data write empties the ready flag on the following cycle
   assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_xbuf |=> !tx_ready);
   // R3: reading the character clears done unless a new one lands
   assert_done_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rbuf && !rx_complete) |=> !done);
   // R5: a confirmed start bit ends the reader-run request
   assert_rdr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_start_ok && !wr_rcsr) |=> !rdr_run);
   // R9: any modem status change raises the flag
   assert_mflag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_now != mod_q) |=> mflag);
endmodule

// File: tb/sl_line_regs_test.sv
module sl_line_regs_test;
   localparam int CLK_PERIOD = 10;
   localparam int RXD_DIV = 16;
   localparam int TXD_DIV = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wdata = '0, rdata;
   logic rxd = 1'b1, txd;
   logic ring = 1'b0, car_det = 1'b0, cts = 1'b0, sec_rx = 1'b0;
   logic dtr, rts, sec_tx, rdr_run, rx_irq, tx_irq;

   int vecs = 0, errs = 0;
   logic [15:0] v;

   sl_line_regs #(.DATA_BITS(8), .PARITY(1), .RX_DIV(RXD_DIV), .TX_DIV(TXD_DIV)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .ring(ring),
      .car_det(car_det), .cts(cts), .sec_rx(sec_rx), .dtr(dtr), .rts(rts),
      .sec_tx(sec_tx), .rdr_run(rdr_run), .rx_irq(rx_irq), .tx_irq(tx_irq));

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rbuf(input logic [7:0] d, input logic o,
                                            input logic f, input logic p);
      return {o | f | p, o, f, p, 4'b0000, d};
   endfunction

   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_done();
      logic [15:0] s;
      for (int i = 0; i < 1500; i++) begin
         bus_rd(3'd0, s);
         if (s[7]) break;
      end
   endtask

   task automatic ext_send(input logic [7:0] d, input logic badpar, input logic badstop);
      @(negedge clk);
      rxd = 1'b0;
      repeat (RXD_DIV) @(negedge clk);
      for (int b = 0; b < 8; b++) begin
         rxd = d[b];
         repeat (RXD_DIV) @(negedge clk);
      end
      rxd = (^d) ^ badpar;
      repeat (RXD_DIV) @(negedge clk);
      if (badstop) begin
         rxd = 1'b0;
         repeat (RXD_DIV / 2 + 2) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (2 * RXD_DIV) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin : main
      logic [7:0] c;
      logic bp, bs;
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(3'd0, v); check("R1 rcsr", v, 16'h0000);
      bus_rd(3'd2, v); check("R1 rbuf", v, 16'h0000);
      bus_rd(3'd4, v); check("R1 xcsr", v, 16'h0080);
      check("R1 irqs", {14'd0, rx_irq, tx_irq}, 16'h0000);

      // R2 modem outputs
      bus_wr(3'd0, 16'h000E);
      check("R2 pins", {13'd0, sec_tx, rts, dtr}, 16'h0007);
      bus_rd(3'd0, v); check("R2 readback", v, 16'h000E);
      bus_wr(3'd0, 16'h0000);

      // R10 tx interrupt
      bus_wr(3'd4, 16'h0040);
      check("R10 tx_irq", {15'd0, tx_irq}, 16'h0001);

      // R8 / R6 loopback with double buffering
      bus_wr(3'd4, 16'h0004);
      bus_wr(3'd6, 16'h00A5);
      bus_wr(3'd6, 16'h003C);
      bus_rd(3'd4, v); check("R6 ready low while held", v, 16'h0004);
      check("R8 txd mark", {15'd0, txd}, 16'h0001);
      wait_done();
      bus_rd(3'd2, v); check("R8 R3 loop char", v, exp_rbuf(8'hA5, 0, 0, 0));
      for (int i = 0; i < 400; i++) begin
         bus_rd(3'd4, v);
         if (v[7]) break;
      end
      check("R6 ready returns", v, 16'h0084);
      wait_done();
      bus_rd(3'd2, v); check("R6 second char", v, exp_rbuf(8'h3C, 0, 0, 0));

      // R3 random loopback characters
      for (int i = 0; i < 6; i++) begin
         c = 8'($urandom);
         bus_wr(3'd6, {8'h00, c});
         wait_done();
         bus_rd(3'd2, v); check("R3 random loop", v, exp_rbuf(c, 0, 0, 0));
      end

      // R4 overrun
      bus_wr(3'd6, 16'h0011);
      bus_wr(3'd6, 16'h0022);
      wait_done();
      repeat (400) @(negedge clk);
      bus_rd(3'd2, v); check("R4 overrun", v, exp_rbuf(8'h22, 1, 0, 0));

      // R5 reader enable
      bus_wr(3'd6, 16'h0055);
      wait_done();
      bus_wr(3'd0, 16'h0001);
      bus_rd(3'd0, v); check("R5 done cleared", v, 16'h0001);
      check("R5 rdr_run", {15'd0, rdr_run}, 16'h0001);
      bus_wr(3'd6, 16'h0066);
      wait_done();
      bus_rd(3'd0, v); check("R5 self clear", v, 16'h0080);
      bus_rd(3'd2, v); check("R5 char", v, exp_rbuf(8'h66, 0, 0, 0));

      // R7 break
      bus_wr(3'd4, 16'h0001);
      check("R7 break low", {15'd0, txd}, 16'h0000);
      bus_wr(3'd4, 16'h0000);
      check("R7 break off", {15'd0, txd}, 16'h0001);

      // R3 / R4 external frames
      ext_send(8'h5A, 0, 0);
      bus_rd(3'd2, v); check("R3 ext char", v, exp_rbuf(8'h5A, 0, 0, 0));
      ext_send(8'h5A, 1, 0);
      bus_rd(3'd2, v); check("R4 parity", v, exp_rbuf(8'h5A, 0, 0, 1));
      ext_send(8'hC3, 0, 1);
      bus_rd(3'd2, v); check("R4 framing", v, exp_rbuf(8'hC3, 0, 1, 0));
      for (int i = 0; i < 4; i++) begin
         c = 8'($urandom); bp = 1'($urandom); bs = 1'($urandom);
         ext_send(c, bp, bs);
         bus_rd(3'd2, v); check("R4 random ext", v, exp_rbuf(c, 0, bs, bp));
      end

      // R9 / R10 modem change
      bus_wr(3'd0, 16'h0020);
      @(negedge clk); ring = 1'b1;
      @(negedge clk);
      check("R10 modem irq", {15'd0, rx_irq}, 16'h0001);
      bus_rd(3'd0, v); check("R9 flag set", v, 16'hC020);
      bus_rd(3'd0, v); check("R9 flag cleared", v, 16'h4020);
      check("R10 irq dropped", {15'd0, rx_irq}, 16'h0000);
      bus_wr(3'd0, 16'h0000);
      @(negedge clk); car_det = 1'b1;
      @(negedge clk);
      check("R10 masked", {15'd0, rx_irq}, 16'h0000);
      bus_rd(3'd0, v); check("R9 cd change", v, 16'hD000);
      @(negedge clk); sec_rx = 1'b1;
      @(negedge clk);
      bus_rd(3'd0, v); check("R9 sec change", v, 16'hD400);

      // R10 receive interrupt
      bus_wr(3'd0, 16'h0040);
      ext_send(8'h81, 0, 0);
      check("R10 rx_irq", {15'd0, rx_irq}, 16'h0001);
      bus_rd(3'd2, v); check("R10 char", v, exp_rbuf(8'h81, 0, 0, 0));
      check("R10 rx_irq clear", {15'd0, rx_irq}, 16'h0000);

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule